// File: doc/BRIEF.md
# Target-Time and Square-Wave Pin Generator

This block drives up to four shared output pins from two independent timing channels. Each channel watches a running time bus (whole seconds plus nanoseconds, kept by a separate clock block) and compares it against a start time that is programmed per channel. When a channel is armed, it chooses one of two behaviours from its programmed half-period. In target-time mode it produces a single event: its pin goes high and a sticky interrupt flag is raised. In square-wave mode its pin goes high at the start time and then toggles every half-period, with no interrupt.

Arming happens on the rising edge of a channel's enable. At that moment the start time, half-period and pin selection are captured, and the operating mode is decided. The half-period decides the mode: short periods and three exact slow periods give a square wave; everything else gives a one-shot target event; square-wave periods that are too short are refused. A channel that owns a pin drives that pin as an output and blocks any input-capture request on it.

Top module: `ttclk_gen`

## Requirements
- R1: After reset, all pin levels, all output enables, all capture enables and both interrupt flags are 0.
- R2: On arming, a half-period that is at most 70,000,000 ns, or exactly 125,000,000, 250,000,000 or 500,000,000 ns, selects square-wave mode. Any other half-period selects target-time mode.
- R3: A half-period below 8 ns that would select square-wave mode is refused. The channel stays inactive: its pin is low, the pin is not enabled as an output and no interrupt is raised.
- R4: In target-time mode the channel's pin goes high, and its interrupt flag is set, on the first clock edge after arming at which the sampled time is at or after the start time. The event fires only once per arming: after the flag is cleared it does not return until the channel is armed again.
- R5: In square-wave mode the pin goes high on the first edge at which the sampled time reaches the start time. It then toggles at each edge where the time reaches start + k·half-period (k = 1, 2, …), carrying across second boundaries. No interrupt is raised.
- R6: Each channel has a 2-bit pin-select field that picks pin 0–3. While a channel is armed in either mode, its selected pin has output enable 1 and carries the channel's level. Pins that no channel owns have level 0 and output enable 0.
- R7: A capture enable is the capture request of its pin, with the request masked to 0 while that pin is enabled as an output.
- R8: Dropping a channel's enable returns the channel to inactive on the next edge, so its pin goes low and its output enable goes to 0. The interrupt flag is kept until it is cleared.
- R9: While a channel stays enabled, changes to its start time, half-period and pin select have no effect until the channel is armed again.
- R10: Pulsing a channel's interrupt-clear input clears its flag. If a new event and a clear arrive on the same edge, the event wins.
- R11: If both channels select the same pin, channel 0 drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_sec_i | input | 32 | Current time, seconds |
| now_ns_i | input | 30 | Current time, nanoseconds (0..999,999,999) |
| ch_en_i | input | 2 | Per-channel enable; rising edge arms the channel |
| ch_start_sec_i | input | 64 | Start time seconds, channel c at bits [32c+31:32c] |
| ch_start_ns_i | input | 60 | Start time nanoseconds, channel c at bits [30c+29:30c] |
| ch_half_i | input | 64 | Half-period in ns, channel c at bits [32c+31:32c] |
| ch_pin_sel_i | input | 4 | Pin select, channel c at bits [2c+1:2c] |
| irq_clr_i | input | 2 | Per-channel interrupt-flag clear |
| cap_req_i | input | 4 | Per-pin input-capture request |
| pin_o | output | 4 | Pin levels |
| pin_oe_o | output | 4 | Pin output enables |
| cap_en_o | output | 4 | Per-pin capture enables after masking |
| irq_o | output | 2 | Per-channel target-event interrupt flags |

## Verification
The bench exercises half-periods on both sides of each mode boundary: 7 and 8 ns, 70,000,000 and one above, and each exact slow value and its neighbour. A wrong comparison there would show up as an interrupt in square-wave mode, or as a refused channel that still drives its pin. It changes the configuration while a channel is armed, and holds a clear asserted across the cycle in which the event fires. These catch a design that relatches its settings, or one that lets the clear beat the event. Its start times cross a second boundary, so a design that mishandles the nanosecond carry would toggle at the wrong edge. It also routes both channels to one pin to check that channel 0 wins.

// File: rtl/ttclk_pkg.sv
package ttclk_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_TT  = 2'd1,
    MODE_CLK = 2'd2
  } mode_e;

  localparam int unsigned NS_PER_SEC    = 1_000_000_000;
  localparam int unsigned FAST_HALF_MAX = 70_000_000;
  localparam int unsigned HALF_MIN      = 8;
  localparam int unsigned SLOW_HALF_A   = 125_000_000;
  localparam int unsigned SLOW_HALF_B   = 250_000_000;
  localparam int unsigned SLOW_HALF_C   = 500_000_000;

endpackage

// File: rtl/ttclk_mode_sel.sv
module ttclk_mode_sel
  import ttclk_pkg::*;
#(
  parameter int          HALF_W   = 32,
  parameter int unsigned FAST_MAX = FAST_HALF_MAX,
  parameter int unsigned MIN_HALF = HALF_MIN
) (
  input  logic [HALF_W-1:0] half_i,
  output mode_e             mode_o
);

  localparam int NSLOW = 3;
  localparam logic [HALF_W-1:0] FAST_LIM = HALF_W'(FAST_MAX);
  localparam logic [HALF_W-1:0] MIN_LIM  = HALF_W'(MIN_HALF);
  localparam logic [NSLOW*HALF_W-1:0] SLOW_SET =
    {HALF_W'(SLOW_HALF_C), HALF_W'(SLOW_HALF_B), HALF_W'(SLOW_HALF_A)};

  logic [NSLOW-1:0] slow_hit;
  logic             wave_ok;
  logic             too_short;

  // one comparator per exact slow half-period
  for (genvar s = 0; s < NSLOW; s++) begin : g_slow
    assign slow_hit[s] = (half_i == SLOW_SET[s*HALF_W +: HALF_W]);
  end

  always_comb begin
    wave_ok   = (half_i <= FAST_LIM) || (|slow_hit);
    too_short = (half_i < MIN_LIM);
    if (!wave_ok)       mode_o = MODE_TT;
    else if (too_short) mode_o = MODE_OFF;
    else                mode_o = MODE_CLK;
  end

endmodule

// File: rtl/ttclk_channel.sv
module ttclk_channel
  import ttclk_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int HALF_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [SEC_W-1:0]  start_sec_i,
  input  logic [NS_W-1:0]   start_ns_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [SEC_W-1:0]  now_sec_i,
  input  logic [NS_W-1:0]   now_ns_i,
  input  logic              irq_clr_i,
  output mode_e             mode_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              level_o,
  output logic              irq_o
);

  localparam logic [NS_W:0] WRAP_NS = (NS_W+1)'(NS_PER_SEC);

  // registers
  logic              en_q;
  mode_e             mode_q,    mode_d;
  logic [SEL_W-1:0]  sel_q,     sel_d;
  logic [SEC_W-1:0]  due_sec_q, due_sec_d;
  logic [NS_W-1:0]   due_ns_q,  due_ns_d;
  logic [NS_W-1:0]   half_q,    half_d;
  logic              fired_q,   fired_d;
  logic              level_q,   level_d;
  logic              irq_q,     irq_d;

  // combinational helpers
  mode_e             pick_mode;
  logic              arm;
  logic              reached;
  logic              irq_set;
  logic [NS_W:0]     ns_sum;

  ttclk_mode_sel #(.HALF_W(HALF_W)) u_mode_sel (
    .half_i (half_i),
    .mode_o (pick_mode)
  );

  assign arm     = en_i & ~en_q;
  assign reached = (now_sec_i > due_sec_q) ||
                   ((now_sec_i == due_sec_q) && (now_ns_i >= due_ns_q));
  assign ns_sum  = {1'b0, due_ns_q} + {1'b0, half_q};

  // next-state logic
  always_comb begin
    mode_d    = mode_q;
    sel_d     = sel_q;
    due_sec_d = due_sec_q;
    due_ns_d  = due_ns_q;
    half_d    = half_q;
    fired_d   = fired_q;
    level_d   = level_q;
    irq_set   = 1'b0;

    if (!en_i) begin
      mode_d  = MODE_OFF;
      level_d = 1'b0;
    end else if (arm) begin
      // both modes cleared, then exactly one chosen
      mode_d    = pick_mode;
      sel_d     = sel_i;
      due_sec_d = start_sec_i;
      due_ns_d  = start_ns_i;
      half_d    = NS_W'(half_i);
      fired_d   = 1'b0;
      level_d   = 1'b0;
    end else begin
      case (mode_q)
        MODE_TT: begin
          if (!fired_q && reached) begin
            fired_d = 1'b1;
            level_d = 1'b1;
            irq_set = 1'b1;
          end
        end
        MODE_CLK: begin
          if (reached) begin
            level_d = ~level_q;
            if (ns_sum >= WRAP_NS) begin
              due_ns_d  = NS_W'(ns_sum - WRAP_NS);
              due_sec_d = due_sec_q + 1'b1;
            end else begin
              due_ns_d  = ns_sum[NS_W-1:0];
            end
          end
        end
        default: ;
      endcase
    end

    irq_d = irq_set | (irq_q & ~irq_clr_i);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      mode_q    <= MODE_OFF;
      sel_q     <= '0;
      due_sec_q <= '0;
      due_ns_q  <= '0;
      half_q    <= '0;
      fired_q   <= 1'b0;
      level_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      en_q      <= en_i;
      mode_q    <= mode_d;
      sel_q     <= sel_d;
      due_sec_q <= due_sec_d;
      due_ns_q  <= due_ns_d;
      half_q    <= half_d;
      fired_q   <= fired_d;
      level_q   <= level_d;
      irq_q     <= irq_d;
    end
  end

  assign mode_o  = mode_q;
  assign sel_o   = sel_q;
  assign level_o = level_q;
  assign irq_o   = irq_q;

  AST_FAST_IS_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && half_i >= HALF_W'(HALF_MIN) && half_i <= HALF_W'(FAST_HALF_MAX))
      |=> (mode_q == MODE_CLK)); // R2
  AST_SHORT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && half_i < HALF_W'(HALF_MIN)) |=> (mode_q == MODE_OFF && !level_q)); // R3
  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TT && fired_q && en_i && !arm) |=> (fired_q && level_q)); // R4
  AST_WAVE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CLK && en_i && !irq_q) |=> !irq_q); // R5
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!level_q && mode_q == MODE_OFF)); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && en_q) |=> $stable(sel_q)); // R9

endmodule

// File: rtl/ttclk_pin_mux.sv
module ttclk_pin_mux #(
  parameter int NCH   = 2,
  parameter int NPIN  = 4,
  parameter int SEL_W = 2
) (
  input  logic [NCH-1:0]       active_i,
  input  logic [NCH*SEL_W-1:0] sel_i,
  input  logic [NCH-1:0]       level_i,
  input  logic [NPIN-1:0]      cap_req_i,
  output logic [NPIN-1:0]      pin_o,
  output logic [NPIN-1:0]      oe_o,
  output logic [NPIN-1:0]      cap_en_o
);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    // walk channels from highest to lowest so channel 0 has the last word
    always_comb begin
      pin_o[p] = 1'b0;
      oe_o[p]  = 1'b0;
      for (int c = NCH - 1; c >= 0; c--) begin
        if (active_i[c] && (sel_i[c*SEL_W +: SEL_W] == SEL_W'(p))) begin
          pin_o[p] = level_i[c];
          oe_o[p]  = 1'b1;
        end
      end
    end
    assign cap_en_o[p] = cap_req_i[p] & ~oe_o[p];
  end

endmodule

// File: rtl/ttclk_gen.sv
module ttclk_gen
  import ttclk_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int NPIN   = 4,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int HALF_W = 32,
  parameter int SEL_W  = $clog2(NPIN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEC_W-1:0]      now_sec_i,
  input  logic [NS_W-1:0]       now_ns_i,
  input  logic [NCH-1:0]        ch_en_i,
  input  logic [NCH*SEC_W-1:0]  ch_start_sec_i,
  input  logic [NCH*NS_W-1:0]   ch_start_ns_i,
  input  logic [NCH*HALF_W-1:0] ch_half_i,
  input  logic [NCH*SEL_W-1:0]  ch_pin_sel_i,
  input  logic [NCH-1:0]        irq_clr_i,
  input  logic [NPIN-1:0]       cap_req_i,
  output logic [NPIN-1:0]       pin_o,
  output logic [NPIN-1:0]       pin_oe_o,
  output logic [NPIN-1:0]       cap_en_o,
  output logic [NCH-1:0]        irq_o
);

  logic [NCH-1:0]       active;
  logic [NCH-1:0]       level;
  logic [NCH*SEL_W-1:0] sel_held;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mode_e ch_mode;

    ttclk_channel #(
      .SEC_W  (SEC_W),
      .NS_W   (NS_W),
      .HALF_W (HALF_W),
      .SEL_W  (SEL_W)
    ) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (ch_en_i[c]),
      .start_sec_i (ch_start_sec_i[c*SEC_W +: SEC_W]),
      .start_ns_i  (ch_start_ns_i[c*NS_W +: NS_W]),
      .half_i      (ch_half_i[c*HALF_W +: HALF_W]),
      .sel_i       (ch_pin_sel_i[c*SEL_W +: SEL_W]),
      .now_sec_i   (now_sec_i),
      .now_ns_i    (now_ns_i),
      .irq_clr_i   (irq_clr_i[c]),
      .mode_o      (ch_mode),
      .sel_o       (sel_held[c*SEL_W +: SEL_W]),
      .level_o     (level[c]),
      .irq_o       (irq_o[c])
    );

    assign active[c] = (ch_mode != MODE_OFF);
  end

  ttclk_pin_mux #(
    .NCH   (NCH),
    .NPIN  (NPIN),
    .SEL_W (SEL_W)
  ) u_mux (
    .active_i  (active),
    .sel_i     (sel_held),
    .level_i   (level),
    .cap_req_i (cap_req_i),
    .pin_o     (pin_o),
    .oe_o      (pin_oe_o),
    .cap_en_o  (cap_en_o)
  );

  AST_CAP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en_o & pin_oe_o) == '0); // R7
  AST_IDLE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en_i == '0) |=> (pin_oe_o == '0 && pin_o == '0)); // R8
  AST_UNOWNED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_o & ~pin_oe_o) == '0); // R6

endmodule

// File: tb/sim_ttclk_gen.sv
module sim_ttclk_gen;

  localparam int NCH = 2, NPIN = 4, SEC_W = 32, NS_W = 30, HALF_W = 32, SEL_W = 2;
  localparam longint unsigned BILLION = 64'd1_000_000_000;
  localparam longint unsigned STEP    = 64'd5;

  logic clk = 1'b0;
  logic rst_n;
  logic [SEC_W-1:0]      now_sec;
  logic [NS_W-1:0]       now_ns;
  logic [NCH-1:0]        ch_en;
  logic [NCH*SEC_W-1:0]  ch_start_sec;
  logic [NCH*NS_W-1:0]   ch_start_ns;
  logic [NCH*HALF_W-1:0] ch_half;
  logic [NCH*SEL_W-1:0]  ch_sel;
  logic [NCH-1:0]        irq_clr;
  logic [NPIN-1:0]       cap_req;
  logic [NPIN-1:0]       pin_o, pin_oe_o, cap_en_o;
  logic [NCH-1:0]        irq_o;

  ttclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .now_sec_i(now_sec), .now_ns_i(now_ns),
    .ch_en_i(ch_en), .ch_start_sec_i(ch_start_sec), .ch_start_ns_i(ch_start_ns),
    .ch_half_i(ch_half), .ch_pin_sel_i(ch_sel), .irq_clr_i(irq_clr),
    .cap_req_i(cap_req), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .cap_en_o(cap_en_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  longint unsigned tnow;

  // stimulus values
  longint unsigned b_start[NCH], b_half[NCH];
  int b_sel[NCH];
  bit b_en[NCH], b_clr[NCH];
  logic [NPIN-1:0] b_cap;

  // reference state
  int e_mode[NCH];
  longint unsigned e_start[NCH], e_half[NCH];
  int e_sel[NCH];
  bit e_fired[NCH], e_irq[NCH], e_enp[NCH], e_fresh[NCH];

  function automatic int mode_of(longint unsigned h);
    if (h <= 64'd70_000_000 || h == 64'd125_000_000 ||
        h == 64'd250_000_000 || h == 64'd500_000_000)
      return (h < 64'd8) ? 0 : 2;
    return 1;
  endfunction

  function automatic bit exp_level(int c, longint unsigned t);
    if (e_mode[c] == 0 || e_fresh[c]) return 1'b0;
    if (e_mode[c] == 1) return e_fired[c];
    if (t < e_start[c]) return 1'b0;
    return (((t - e_start[c]) / e_half[c]) % 2) == 0;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive_time();
    now_sec = SEC_W'(tnow / BILLION);
    now_ns  = NS_W'(tnow % BILLION);
  endtask

  task automatic push();
    for (int c = 0; c < NCH; c++) begin
      ch_en[c]   = b_en[c];
      irq_clr[c] = b_clr[c];
      ch_start_sec[c*SEC_W +: SEC_W] = SEC_W'(b_start[c] / BILLION);
      ch_start_ns[c*NS_W +: NS_W]    = NS_W'(b_start[c] % BILLION);
      ch_half[c*HALF_W +: HALF_W]    = HALF_W'(b_half[c]);
      ch_sel[c*SEL_W +: SEL_W]       = SEL_W'(b_sel[c]);
    end
    cap_req = b_cap;
  endtask

  task automatic cyc(string tag);
    logic [NPIN-1:0] ep, eo;
    bit set;
    push();
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      set = 1'b0;
      if (!b_en[c]) begin
        e_mode[c] = 0; e_fresh[c] = 1'b0;
      end else if (!e_enp[c]) begin
        e_mode[c] = mode_of(b_half[c]); e_start[c] = b_start[c];
        e_half[c] = b_half[c]; e_sel[c] = b_sel[c];
        e_fired[c] = 1'b0; e_fresh[c] = 1'b1;
      end else begin
        e_fresh[c] = 1'b0;
        if (e_mode[c] == 1 && !e_fired[c] && tnow >= e_start[c]) begin
          e_fired[c] = 1'b1; set = 1'b1;
        end
      end
      if (set) e_irq[c] = 1'b1;
      else if (b_clr[c]) e_irq[c] = 1'b0;
      e_enp[c] = b_en[c];
    end
    ep = '0; eo = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (e_mode[c] != 0) begin
        ep[e_sel[c]] = exp_level(c, tnow);
        eo[e_sel[c]] = 1'b1;
      end
    #1;
    check(pin_o == ep, tag, "pin_o", longint'(pin_o), longint'(ep));
    check(pin_oe_o == eo, tag, "pin_oe_o", longint'(pin_oe_o), longint'(eo));
    check(cap_en_o == (b_cap & ~eo), tag, "cap_en_o (R7)", longint'(cap_en_o),
          longint'(b_cap & ~eo));
    check(irq_o == {e_irq[1], e_irq[0]}, tag, "irq_o", longint'(irq_o),
          longint'({e_irq[1], e_irq[0]}));
    @(negedge clk);
    tnow += STEP;
    drive_time();
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic idle_all();
    b_en[0] = 1'b0; b_en[1] = 1'b0; b_clr[0] = 1'b1; b_clr[1] = 1'b1;
    cyc("R8");
    b_clr[0] = 1'b0; b_clr[1] = 1'b0;
    cyc("R8");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    longint unsigned halves[9];
    void'($urandom(32'h5EED_1234));
    tnow = 64'd5 * BILLION - 64'd2000;
    drive_time();
    for (int c = 0; c < NCH; c++) begin
      b_start[c] = 0; b_half[c] = 100; b_sel[c] = c; b_en[c] = 0; b_clr[c] = 0;
      e_mode[c] = 0; e_fired[c] = 0; e_irq[c] = 0; e_enp[c] = 0; e_fresh[c] = 0;
    end
    b_cap = '0;
    push();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(pin_o == '0, "R1", "pin_o", longint'(pin_o), 0);
    check(pin_oe_o == '0, "R1", "pin_oe_o", longint'(pin_oe_o), 0);
    check(irq_o == '0, "R1", "irq_o", longint'(irq_o), 0);
    check(cap_en_o == '0, "R1", "cap_en_o", longint'(cap_en_o), 0);
    @(negedge clk);

    // R3 refused short half-periods
    for (int k = 0; k < 2; k++) begin
      b_half[0] = (k == 0) ? 64'd7 : 64'd0;
      b_start[0] = tnow + 2 * STEP; b_sel[0] = 1; b_en[0] = 1'b1; b_cap = 4'b0010;
      run(10, "R3");
      check(pin_oe_o[1] == 1'b0, "R3", "pin_oe_o[1]", longint'(pin_oe_o[1]), 0);
      check(pin_o[1] == 1'b0, "R3", "pin_o[1]", longint'(pin_o[1]), 0);
      check(irq_o[0] == 1'b0, "R3", "irq_o[0]", longint'(irq_o[0]), 0);
      b_cap = '0;
      idle_all();
    end

    // R2 mode boundaries
    halves = '{64'd8, 64'd70_000_000, 64'd70_000_001, 64'd125_000_000, 64'd125_000_001,
               64'd250_000_000, 64'd500_000_000, 64'd500_000_001, 64'd999_999_999};
    foreach (halves[i]) begin
      b_half[0] = halves[i]; b_start[0] = tnow + 3 * STEP; b_sel[0] = 0; b_en[0] = 1'b1;
      run(8, "R2");
      check(irq_o[0] == (mode_of(halves[i]) == 1), "R2", "irq_o[0] by half-period",
            longint'(irq_o[0]), longint'(mode_of(halves[i]) == 1));
      idle_all();
    end

    // R9 config changes while armed, then R10 clear and R4 fire-once
    b_half[1] = 64'd80_000_000; b_start[1] = tnow + 4 * STEP; b_sel[1] = 2; b_en[1] = 1'b1;
    cyc("R9");
    b_start[1] = tnow + 64'd1_000_000; b_sel[1] = 3; b_half[1] = 64'd40;
    run(8, "R9");
    check(pin_o[2] == 1'b1, "R9", "pin_o[2]", longint'(pin_o[2]), 1);
    check(pin_oe_o[3] == 1'b0, "R9", "pin_oe_o[3]", longint'(pin_oe_o[3]), 0);
    b_clr[1] = 1'b1;
    cyc("R10");
    b_clr[1] = 1'b0;
    run(10, "R4");
    check(irq_o[1] == 1'b0, "R4", "irq_o[1] after clear", longint'(irq_o[1]), 0);
    check(pin_o[2] == 1'b1, "R4", "pin_o[2] held", longint'(pin_o[2]), 1);
    idle_all();

    // R10 clear held across the firing edge
    b_half[1] = 64'd90_000_000; b_start[1] = tnow + 3 * STEP; b_sel[1] = 0;
    b_en[1] = 1'b1; b_clr[1] = 1'b1;
    run(6, "R10");
    b_clr[1] = 1'b0;
    idle_all();

    // R11 both channels on one pin
    b_half[0] = 64'd20; b_start[0] = tnow + 2 * STEP; b_sel[0] = 1; b_en[0] = 1'b1;
    b_half[1] = 64'd75_000_000; b_start[1] = tnow + 30 * STEP; b_sel[1] = 1; b_en[1] = 1'b1;
    run(40, "R11");
    idle_all();

    // R8 disable returns pin low
    b_half[0] = 64'd10; b_start[0] = tnow + 2 * STEP; b_sel[0] = 3; b_en[0] = 1'b1;
    run(7, "R5");
    b_en[0] = 1'b0;
    cyc("R8");
    check(pin_o[3] == 1'b0, "R8", "pin_o[3]", longint'(pin_o[3]), 0);
    check(pin_oe_o[3] == 1'b0, "R8", "pin_oe_o[3]", longint'(pin_oe_o[3]), 0);
    idle_all();

    // random trials: R5 R6 R7
    for (int tr = 0; tr < 25; tr++) begin
      for (int c = 0; c < NCH; c++) begin
        if ($urandom % 2 == 0) b_half[c] = 64'd8 + longint'($urandom % 193);
        else                   b_half[c] = 64'd70_000_001 + longint'($urandom % 1000);
        b_start[c] = tnow + longint'($urandom % 400);
        b_sel[c] = int'($urandom % 4);
        b_en[c] = 1'b1;
      end
      for (int i = 0; i < 200; i++) begin
        b_cap = NPIN'($urandom);
        cyc("R5 R6 R7");
      end
      b_cap = '0;
      idle_all();
    end

    finish_run();
  end

endmodule